// File: doc/BRIEF.md
# Register-Move and Logic Execute Unit

This block is an 8-bit execute stage. It holds seven general registers and a flag register. The general registers are the accumulator A, plus B, C, D, E, H and L. Instructions arrive on a valid/ready stream. Each beat carries one opcode and a 16-bit immediate field. Only the opcodes that need an operand read that field.

The unit supports four kinds of operation:
- register-to-register copies;
- accumulator arithmetic and logic (ADD, SUB, AND, OR), taking either a register or an immediate byte as the operand;
- a 16-bit immediate load into the H/L pair;
- a 16-bit decrement of the H/L pair.

A copy uses a source multiplexer and a destination multiplexer. No logic checks whether the two select the same register, so copying a register onto itself simply does nothing. An accumulator logic operation applied to A itself always rewrites the flags. This is the usual way to test A for zero.

Every register and the flag byte are visible on plain output pins. A one-cycle strobe marks any opcode the unit does not execute.

Back-pressure rules: `in_ready` is high in every cycle outside reset, so the unit never stalls. A beat is consumed on each rising edge where `in_valid` and `in_ready` are both high. Its effects appear on the outputs from that edge on. The producer may present a new beat in every cycle.

Top module: `regmove_logic_exu`

## Requirements
- R1: After a synchronous active-low reset, all seven registers and the flag byte read 0x00, and `illegal_o` is low.
- R2: Opcode `01 ddd sss` copies the register selected by sss into the register selected by ddd, and leaves the flags unchanged. The select codes are A=111, B=000, C=001, D=010, E=011, H=100, L=101. The copy is visible in the cycle after acceptance.
- R3: A copy whose source and destination codes are equal changes no register and no flag.
- R4: AND is encoded as `10100sss` for a register operand or 0xE6 for an immediate operand. It writes A & operand to A and sets Z from the result, with N=0, H=1 and C=0. AND A therefore keeps A and sets Z exactly when A is zero.
- R5: OR is encoded as `10110sss` or 0xF6. It writes A | operand to A and sets Z from the result, with N=0, H=0 and C=0.
- R6: ADD is encoded as `10000sss` or 0xC6. It writes the 8-bit sum to A and sets Z from it, with N=0. H is the carry out of bit 3 and C is the carry out of bit 7.
- R7: SUB is encoded as `10010sss` or 0xD6. It writes A - operand to A and sets Z from it, with N=1. C is set on a borrow out of bit 7 and H on a borrow out of bit 3.
- R8: Opcode 0x21 loads the immediate's low byte (bits 7:0) into L and its high byte (bits 15:8) into H. The flags are left unchanged.
- R9: Opcode 0x2B decrements the H/L pair as one 16-bit value, wrapping from 0x0000 to 0xFFFF. The flags are left unchanged.
- R10: Any other opcode raises `illegal_o` for exactly the cycle after acceptance and leaves all registers and flags unchanged. This covers select code 110 in either field, 0x76, ADC/SBC/XOR/CP, and 0x00.
- R11: The flag byte places Z at bit 7, N at bit 6, H at bit 5 and C at bit 4. Bits 3:0 always read 0.
- R12: `in_ready` is high whenever `rst_n` is high. In a cycle with `in_valid` low, no register or flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction beat is present |
| in_ready | output | 1 | Unit accepts a beat this cycle |
| in_op | input | 8 | Opcode byte |
| in_imm | input | 16 | Immediate, low byte in bits 7:0 |
| acc_o | output | 8 | Register A |
| b_o | output | 8 | Register B |
| c_o | output | 8 | Register C |
| d_o | output | 8 | Register D |
| e_o | output | 8 | Register E |
| h_o | output | 8 | Register H |
| l_o | output | 8 | Register L |
| flags_o | output | 8 | Flag byte Z,N,H,C,0,0,0,0 |
| illegal_o | output | 1 | One-cycle strobe for an unexecuted opcode |

## Verification
The assertions check five properties in every cycle:
- a self-copy leaves the whole architectural state unchanged;
- a rejected opcode leaves the whole state unchanged and raises the strobe;
- the two pair operations never touch the flags;
- the decrement wraps at zero;
- an idle cycle changes nothing.

The bench scenarios are needed for the data results. These are the copy routing for each select code, the flag values for carries and borrows, zero results from AND A and OR A, and the byte order of the 16-bit load. These results can only be compared against a model that the bench drives with back-to-back instruction streams.

// File: rtl/exu_pkg.sv
package exu_pkg;
  typedef enum logic [2:0] {K_ILL, K_MOV, K_ALU, K_LDHL, K_DECHL} kind_e;
  // order matches opcode bits [5:4] of the ALU groups
  typedef enum logic [1:0] {OP_ADD, OP_SUB, OP_AND, OP_OR} aluop_e;

  localparam int NSEL = 8;
  localparam logic [2:0] SEL_HOLE = 3'b110;
  localparam logic [2:0] SEL_A    = 3'b111;
  localparam logic [2:0] SEL_H    = 3'b100;
  localparam logic [2:0] SEL_L    = 3'b101;

  localparam logic [7:0] OPC_LD_PAIR  = 8'h21;
  localparam logic [7:0] OPC_DEC_PAIR = 8'h2B;

  typedef struct packed {
    kind_e      kind;
    aluop_e     aop;
    logic       use_imm;
    logic [2:0] dst;
    logic [2:0] src;
  } dec_t;
endpackage

// File: rtl/exu_decode.sv
module exu_decode
  import exu_pkg::*;
(
  input  logic [7:0] op,
  output dec_t       d
);
  always_comb begin
    d.kind    = K_ILL;
    d.aop     = aluop_e'(op[5:4]);
    d.use_imm = 1'b0;
    d.dst     = op[5:3];
    d.src     = op[2:0];
    if (op[7:6] == 2'b01) begin
      if (op[5:3] != SEL_HOLE && op[2:0] != SEL_HOLE) d.kind = K_MOV;
    end else if (op[7:6] == 2'b10) begin
      if (op[3] == 1'b0 && op[2:0] != SEL_HOLE) begin
        d.kind = K_ALU;
        d.dst  = SEL_A;
      end
    end else if (op[7:6] == 2'b11) begin
      if (op[3] == 1'b0 && op[2:0] == 3'b110) begin
        d.kind    = K_ALU;
        d.use_imm = 1'b1;
        d.dst     = SEL_A;
      end
    end else if (op == OPC_LD_PAIR) begin
      d.kind = K_LDHL;
    end else if (op == OPC_DEC_PAIR) begin
      d.kind = K_DECHL;
    end
  end
endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  aluop_e        aop,
  output logic [DW-1:0] res,
  output logic [3:0]    znhc
);
  localparam int HW = DW / 2;

  logic [DW:0] wide;
  logic [HW:0] half;
  logic        hbit, cbit, nbit;

  always_comb begin
    wide = '0;
    half = '0;
    hbit = 1'b0;
    cbit = 1'b0;
    nbit = 1'b0;
    unique case (aop)
      OP_ADD: begin
        wide = {1'b0, a} + {1'b0, b};
        half = {1'b0, a[HW-1:0]} + {1'b0, b[HW-1:0]};
        hbit = half[HW];
        cbit = wide[DW];
      end
      OP_SUB: begin
        wide = {1'b0, a} - {1'b0, b};
        half = {1'b0, a[HW-1:0]} - {1'b0, b[HW-1:0]};
        hbit = half[HW];
        cbit = wide[DW];
        nbit = 1'b1;
      end
      OP_AND: begin
        wide = {1'b0, a & b};
        hbit = 1'b1;
      end
      OP_OR: begin
        wide = {1'b0, a | b};
      end
    endcase
    res  = wide[DW-1:0];
    znhc = {(wide[DW-1:0] == '0), nbit, hbit, cbit};
  end
endmodule

// File: rtl/exu_regfile.sv
module exu_regfile
  import exu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [2:0]    wsel,
  input  logic [DW-1:0] wdata,
  input  logic          pair_we,
  input  logic [2*DW-1:0] pair_data,
  input  logic [2:0]    rsel,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] q [NSEL]
);
  for (genvar g = 0; g < NSEL; g++) begin : g_reg
    if (g == int'(SEL_HOLE)) begin : g_hole
      assign q[g] = '0;
    end else begin : g_cell
      logic [DW-1:0] r;
      always_ff @(posedge clk) begin
        if (!rst_n)
          r <= '0;
        else if (pair_we && g == int'(SEL_H))
          r <= pair_data[2*DW-1:DW];
        else if (pair_we && g == int'(SEL_L))
          r <= pair_data[DW-1:0];
        else if (we && wsel == 3'(g))
          r <= wdata;
      end
      assign q[g] = r;
    end
  end

  assign rdata = q[rsel];
endmodule

// File: rtl/regmove_logic_exu.sv
module regmove_logic_exu
  import exu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_op,
  input  logic [2*DW-1:0] in_imm,
  output logic [DW-1:0] acc_o,
  output logic [DW-1:0] b_o,
  output logic [DW-1:0] c_o,
  output logic [DW-1:0] d_o,
  output logic [DW-1:0] e_o,
  output logic [DW-1:0] h_o,
  output logic [DW-1:0] l_o,
  output logic [DW-1:0] flags_o,
  output logic          illegal_o
);
  localparam int PW = 2 * DW;

  dec_t          d;
  logic          fire;
  logic [DW-1:0] rdata, operand, alu_res, wdata;
  logic [3:0]    znhc;
  logic [DW-1:0] q [NSEL];
  logic [PW-1:0] pair, pair_next;
  logic [DW-1:0] flags_q;
  logic          ill_q;
  logic          we, pair_we;

  assign in_ready = rst_n;
  assign fire     = in_valid && in_ready;

  exu_decode u_dec (.op(in_op), .d(d));

  assign operand = d.use_imm ? in_imm[DW-1:0] : rdata;

  exu_alu #(.DW(DW)) u_alu (
    .a(q[SEL_A]), .b(operand), .aop(d.aop), .res(alu_res), .znhc(znhc)
  );

  assign pair      = {q[SEL_H], q[SEL_L]};
  assign pair_next = (d.kind == K_LDHL) ? in_imm : pair - PW'(1);
  assign we        = fire && (d.kind == K_MOV || d.kind == K_ALU);
  assign pair_we   = fire && (d.kind == K_LDHL || d.kind == K_DECHL);
  assign wdata     = (d.kind == K_MOV) ? rdata : alu_res;

  exu_regfile #(.DW(DW)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(we), .wsel(d.dst), .wdata(wdata),
    .pair_we(pair_we), .pair_data(pair_next), .rsel(d.src),
    .rdata(rdata), .q(q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      ill_q   <= 1'b0;
    end else begin
      ill_q <= fire && (d.kind == K_ILL);
      if (fire && d.kind == K_ALU) flags_q <= {znhc, {(DW-4){1'b0}}};
    end
  end

  assign acc_o     = q[SEL_A];
  assign b_o       = q[3'b000];
  assign c_o       = q[3'b001];
  assign d_o       = q[3'b010];
  assign e_o       = q[3'b011];
  assign h_o       = q[SEL_H];
  assign l_o       = q[SEL_L];
  assign flags_o   = flags_q;
  assign illegal_o = ill_q;

  logic [8*DW-1:0] snap;
  assign snap = {acc_o, b_o, c_o, d_o, e_o, h_o, l_o, flags_q};

  AST_SELF_COPY_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && d.kind == K_MOV && d.src == d.dst) |=> $stable(snap)); // R3
  AST_ILLEGAL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && d.kind == K_ILL) |=> ($stable(snap) && illegal_o)); // R10
  AST_PAIR_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (d.kind == K_LDHL || d.kind == K_DECHL)) |=> $stable(flags_o)); // R9
  AST_DEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && d.kind == K_DECHL && pair == '0) |=> ({h_o, l_o} == {PW{1'b1}})); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid) |=> $stable(snap)); // R12
endmodule

// File: tb/tb_regmove_logic_exu.sv
module tb_regmove_logic_exu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_op = 8'h00;
  logic [15:0] in_imm = 16'h0000;
  logic [7:0]  acc_o, b_o, c_o, d_o, e_o, h_o, l_o, flags_o;
  logic        illegal_o;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  regmove_logic_exu dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_imm(in_imm), .acc_o(acc_o), .b_o(b_o), .c_o(c_o),
    .d_o(d_o), .e_o(e_o), .h_o(h_o), .l_o(l_o), .flags_o(flags_o),
    .illegal_o(illegal_o)
  );

  typedef struct {
    logic [64:0] state;
    string       tag;
  } exp_t;
  exp_t q_exp[$];

  // bench model, indexed by select code (A=7,B=0,C=1,D=2,E=3,H=4,L=5)
  logic [7:0] mr [8];
  logic [7:0] mf;
  logic       mill;

  function automatic logic [64:0] observed();
    return {acc_o, b_o, c_o, d_o, e_o, h_o, l_o, flags_o, illegal_o};
  endfunction

  function automatic logic [64:0] modeled();
    return {mr[7], mr[0], mr[1], mr[2], mr[3], mr[4], mr[5], mf, mill};
  endfunction

  task automatic check(input string tag, input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_exec(input logic [7:0] op, input logic [15:0] imm);
    logic [7:0] x, r;
    logic [8:0] w;
    logic [4:0] hw;
    mill = 1'b0;
    if (op[7:6] == 2'b01 && op[5:3] != 3'd6 && op[2:0] != 3'd6) begin
      mr[op[5:3]] = mr[op[2:0]];
    end else if ((op[7:6] == 2'b10 && op[3] == 1'b0 && op[2:0] != 3'd6) ||
                 (op[7:6] == 2'b11 && op[3] == 1'b0 && op[2:0] == 3'd6)) begin
      x = (op[7:6] == 2'b11) ? imm[7:0] : mr[op[2:0]];
      case (op[5:4])
        2'b00: begin
          w = {1'b0, mr[7]} + {1'b0, x}; hw = {1'b0, mr[7][3:0]} + {1'b0, x[3:0]};
          r = w[7:0]; mf = {r == 0, 1'b0, hw[4], w[8], 4'h0};
        end
        2'b01: begin
          r = mr[7] - x;
          mf = {r == 0, 1'b1, mr[7][3:0] < x[3:0], mr[7] < x, 4'h0};
        end
        2'b10: begin r = mr[7] & x; mf = {r == 0, 3'b010, 4'h0}; end
        default: begin r = mr[7] | x; mf = {r == 0, 3'b000, 4'h0}; end
      endcase
      mr[7] = r;
    end else if (op == 8'h21) begin
      mr[4] = imm[15:8]; mr[5] = imm[7:0];
    end else if (op == 8'h2B) begin
      {mr[4], mr[5]} = {mr[4], mr[5]} - 16'd1;
    end else begin
      mill = 1'b1;
    end
  endtask

  // driver: presents one beat per call, back to back
  task automatic send(input logic [7:0] op, input logic [15:0] imm, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_imm = imm;
    model_exec(op, imm);
    e.state = modeled();
    e.tag = tag;
    q_exp.push_back(e);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0; in_op = 8'hA7; in_imm = 16'hFFFF;
    mill = 1'b0;
    for (int i = 1; i < n; i++) @(negedge clk);
  endtask

  // monitor: compares one cycle after each accepted beat
  initial begin
    forever begin
      logic f;
      exp_t e;
      @(posedge clk);
      f = in_valid && in_ready;
      @(negedge clk);
      if (f) begin
        e = q_exp.pop_front();
        check(e.tag, observed(), e.state);
        check("R11", {61'd0, flags_o[3:0]}, 65'd0);
      end
    end
  end

  initial begin
    #(8 * 20000);
    failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mr[i] = 8'h00;
    mf = 8'h00; mill = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", observed(), 65'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12", {64'd0, in_ready}, 65'd1);

    send(8'h21, 16'h1234, "R8");
    send(8'h7C, 16'h0, "R2");   // A <- H
    send(8'h45, 16'h0, "R2");   // B <- L
    send(8'h4F, 16'h0, "R2");   // C <- A
    send(8'h50, 16'h0, "R2");   // D <- B
    send(8'h59, 16'h0, "R2");   // E <- C
    send(8'h40, 16'h0, "R3");   // B <- B
    send(8'h7F, 16'h0, "R3");   // A <- A
    send(8'h64, 16'h0, "R3");   // H <- H
    send(8'hA7, 16'h0, "R4");   // AND A, A=0x12
    send(8'hE6, 16'h0000, "R4");
    send(8'hA7, 16'h0, "R4");   // AND A with A=0
    send(8'hB7, 16'h0, "R5");   // OR A with A=0
    send(8'hF6, 16'h005A, "R5");
    send(8'hB7, 16'h0, "R5");
    send(8'hA0, 16'h0, "R4");   // AND B
    send(8'hE6, 16'h0000, "R4");
    send(8'hC6, 16'h000F, "R6");
    send(8'hC6, 16'h0001, "R6");
    send(8'hC6, 16'h00F0, "R6");
    send(8'hD6, 16'h0001, "R7");
    send(8'hD6, 16'h00FF, "R7");
    send(8'h80, 16'h0, "R6");   // ADD B
    send(8'h92, 16'h0, "R7");   // SUB D
    send(8'h93, 16'h0, "R7");   // SUB E -> borrow
    send(8'h2B, 16'h0, "R9");
    send(8'h21, 16'h0000, "R8");
    send(8'h2B, 16'h0, "R9");   // wrap
    send(8'h2B, 16'h0, "R9");
    send(8'h76, 16'h0, "R10");
    send(8'h46, 16'h0, "R10");
    send(8'h70, 16'h0, "R10");
    send(8'hA6, 16'h0, "R10");
    send(8'h88, 16'h0, "R10");
    send(8'hAF, 16'h0, "R10");
    send(8'h00, 16'h0, "R10");
    send(8'hFE, 16'h0, "R10");
    send(8'h67, 16'h0, "R2");   // H <- A
    send(8'h6B, 16'h0, "R2");   // L <- E
    idle(4);
    check("R12", observed(), modeled());
    send(8'hF6, 16'h0081, "R5");
    idle(3);
    check("R12", observed(), modeled());
    if (q_exp.size() != 0) check("R12", 65'(q_exp.size()), 65'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule